// File: doc/BRIEF.md
# FSK Modem Handshake Timing Controller

This block sequences the digital control side of a half-duplex 1200 bit/s FSK modem. It sits between the data terminal and the modulator/demodulator. It turns the terminal's request-to-send into a delayed clear-to-send. It filters the demodulator's fast carrier flag into a debounced carrier-detect. It gates the demodulated data so that the terminal sees a steady mark whenever that data cannot be trusted. It also drives the enable that lets the transmitter put its carrier on the line.

All delays are counted in ticks of a slow timebase. That timebase is the master clock divided by `TICK_DIV`. With a 3.579545 MHz master clock and the default divider of 4096, one tick is about 1.144 ms. A two-bit timing select picks one of three built-in delay sets, or an external mode that takes the already-delayed clear-to-send and carrier-detect from outside logic. A loopback mode connects the terminal to itself for testing. Every asynchronous input passes through a two-flop synchronizer, and every output is registered.

Top module: `fsk_link_sequencer`

## Requirements
- R1: Request-to-send, clear-to-send, carrier flag and carrier-detect are active low. In reset and straight after it, cts_n=1, cd_n=1, rx_data=1 (mark) and tx_carrier_en=0.
- R2: With rts_n held low and loopback off, cts_n goes low after a number of ticks set by tsel: 175 for 2'b00, 26 for 2'b01, 61 for 2'b10. One tick is TICK_DIV clocks.
- R3: When rts_n returns high, cts_n goes high within 4 clocks, for every tsel value.
- R4: In the internal modes, cd_n goes low once car_flag_n has been low for 9 consecutive ticks, and goes high once it has been high for 4 consecutive ticks. A flag change before the count completes restarts the count.
- R5: While sq_off=0 and rts_n is low, rx_data is mark (1). After rts_n returns high, rx_data stays mark for a squelch hold of 131 ticks (tsel 2'b00 or 2'b01) or 35 ticks (tsel 2'b10). A new request during the hold restarts the hold from the next release.
- R6: Outside loopback, rx_data is mark while carrier-detect is off.
- R7: With sq_off=1 there is no squelch. rx_data follows rx_raw while carrier-detect is on, whether or not rts_n is low, and also right after a release.
- R8: With loop_en=1, rx_data follows tx_data, cts_n follows rts_n with no timed delay, and tx_carrier_en is the inverse of car_ctl_n.
- R9: With tsel=2'b11, cts_n follows ext_cts_n while rts_n is low, and cd_n follows ext_cd_n. There is no internal squelch hold; muting applies only while rts_n is low.
- R10: Outside loopback, tx_carrier_en is high exactly while rts_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_n | input | 1 | Request-to-send, low = on |
| car_flag_n | input | 1 | Fast carrier flag from the level comparator, low = carrier present |
| rx_raw | input | 1 | Raw demodulated data, 1 = mark |
| tx_data | input | 1 | Transmit data from the terminal |
| sq_off | input | 1 | High removes the receive squelch (four-wire use) |
| loop_en | input | 1 | High selects digital loopback |
| car_ctl_n | input | 1 | Carrier control used in loopback, low = carrier on |
| ext_cts_n | input | 1 | Externally delayed clear-to-send (tsel=11) |
| ext_cd_n | input | 1 | Externally delayed carrier-detect (tsel=11) |
| tsel | input | 2 | Delay set select; 2'b11 = external |
| cts_n | output | 1 | Clear-to-send, low = on |
| cd_n | output | 1 | Delayed carrier-detect, low = on |
| rx_data | output | 1 | Gated receive data, 1 = mark |
| tx_carrier_en | output | 1 | Enables the modulator carrier onto the line |

## Verification
A timer stuck or counting against the wrong target shows up at cts_n or cd_n as an edge outside its window of one tick. The bench brackets each delay with one sample before the earliest legal edge and one after the latest. A squelch-pending flag that is wrong holds rx_data at mark for a whole hold period too long, or releases space data during the request. Both show up as a wrong rx_data level within one hold period of the release. A carrier-detect state that did not restart on a flag glitch turns carrier-detect on several ticks early. The glitch test catches that.

// File: rtl/fsk_seq_pkg.sv
package fsk_seq_pkg;

  typedef enum logic [1:0] {
    TSEL_LONG  = 2'b00,
    TSEL_SHORT = 2'b01,
    TSEL_MID   = 2'b10,
    TSEL_EXT   = 2'b11
  } tsel_e;

  // Tick count chosen by the timing select; the external code yields zero.
  function automatic int unsigned pick_ticks(input logic [1:0] sel,
                                             input int unsigned t_long,
                                             input int unsigned t_short,
                                             input int unsigned t_mid);
    int unsigned r;
    case (sel)
      TSEL_LONG:  r = t_long;
      TSEL_SHORT: r = t_short;
      TSEL_MID:   r = t_mid;
      default:    r = 0;
    endcase
    return r;
  endfunction

  // Receive gating: mark unless carrier is present and nothing mutes.
  function automatic logic rx_gate(input logic raw, input logic cd_on,
                                   input logic mute);
    return (cd_on && !mute) ? raw : 1'b1;
  endfunction

endpackage

// File: rtl/fsk_sync.sv
module fsk_sync #(
  parameter int unsigned      W   = 1,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int unsigned DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R2: the timebase is a single-cycle pulse
      assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fsk_delay_timer.sv
module fsk_delay_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cond,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           count <= '0;
    else if (!cond)                       count <= '0;
    else if (tick && (count < target))    count <= count + 1'b1;
  end

  assign done = cond && (count >= target);

  // R2: completion is only ever reached on a timebase tick
  assert_done_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $stable(target) && (target != '0)) |-> $past(tick));
endmodule

// File: rtl/fsk_link_sequencer.sv
module fsk_link_sequencer
  import fsk_seq_pkg::*;
#(
  parameter int unsigned TICK_DIV        = 4096,
  parameter int unsigned CNT_W           = 8,
  parameter int unsigned CTS_TICKS_LONG  = 175,
  parameter int unsigned CTS_TICKS_SHORT = 26,
  parameter int unsigned CTS_TICKS_MID   = 61,
  parameter int unsigned CD_ON_TICKS     = 9,
  parameter int unsigned CD_OFF_TICKS    = 4,
  parameter int unsigned SQ_TICKS_LONG   = 131,
  parameter int unsigned SQ_TICKS_MID    = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rts_n,
  input  logic       car_flag_n,
  input  logic       rx_raw,
  input  logic       tx_data,
  input  logic       sq_off,
  input  logic       loop_en,
  input  logic       car_ctl_n,
  input  logic       ext_cts_n,
  input  logic       ext_cd_n,
  input  logic [1:0] tsel,
  output logic       cts_n,
  output logic       cd_n,
  output logic       rx_data,
  output logic       tx_carrier_en
);
  localparam int unsigned NSYNC = 9;
  // order: rts, flag, raw, txd, sq_off, loop, car_ctl, ext_cts, ext_cd
  localparam logic [NSYNC-1:0] SYNC_RST = 9'b1111_0011_1;

  logic [NSYNC-1:0] async_in, sync_out;
  logic rts_n_s, flag_n_s, raw_s, tx_s, sq_off_s, loop_s, car_ctl_n_s;
  logic ext_cts_n_s, ext_cd_n_s;

  assign async_in = {rts_n, car_flag_n, rx_raw, tx_data, sq_off, loop_en,
                     car_ctl_n, ext_cts_n, ext_cd_n};

  fsk_sync #(.W(NSYNC), .RST(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );

  assign {rts_n_s, flag_n_s, raw_s, tx_s, sq_off_s, loop_s, car_ctl_n_s,
          ext_cts_n_s, ext_cd_n_s} = sync_out;

  // Named internal events
  logic tick, rts_on, flag_on, ext_mode, sq_en;
  assign rts_on   = !rts_n_s;
  assign flag_on  = !flag_n_s;
  assign ext_mode = (tsel == TSEL_EXT);
  assign sq_en    = !sq_off_s;

  fsk_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // Request-to-send to clear-to-send timer
  logic             cts_cond, cts_done;
  logic [CNT_W-1:0] cts_target;
  assign cts_cond   = rts_on && !ext_mode && !loop_s;
  assign cts_target = CNT_W'(pick_ticks(tsel, CTS_TICKS_LONG,
                                        CTS_TICKS_SHORT, CTS_TICKS_MID));

  fsk_delay_timer #(.CW(CNT_W)) u_cts_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cts_cond),
    .target(cts_target), .done(cts_done)
  );

  // Carrier detect: one timer, target picked by the direction of change
  logic             cd_state, cd_cond, cd_done;
  logic [CNT_W-1:0] cd_target;
  assign cd_cond   = (flag_on != cd_state);
  assign cd_target = cd_state ? CNT_W'(CD_OFF_TICKS) : CNT_W'(CD_ON_TICKS);

  fsk_delay_timer #(.CW(CNT_W)) u_cd_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cd_cond),
    .target(cd_target), .done(cd_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cd_state <= 1'b0;
    else if (cd_done) cd_state <= !cd_state;
  end

  // Receive squelch hold after a request ends
  logic             sq_pend, sq_cond, sq_done, mute;
  logic [CNT_W-1:0] sq_target;
  assign sq_cond   = sq_pend && !rts_on && sq_en && !ext_mode;
  assign sq_target = CNT_W'(pick_ticks(tsel, SQ_TICKS_LONG,
                                       SQ_TICKS_LONG, SQ_TICKS_MID));

  fsk_delay_timer #(.CW(CNT_W)) u_sq_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(sq_cond),
    .target(sq_target), .done(sq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sq_pend <= 1'b0;
    else if (!sq_en || ext_mode)  sq_pend <= 1'b0;
    else if (rts_on)              sq_pend <= 1'b1;
    else if (sq_done)             sq_pend <= 1'b0;
  end

  assign mute = sq_en && (rts_on || sq_pend);

  // Output selection
  logic cts_on_nx, cd_on_eff;
  assign cd_on_eff = ext_mode ? !ext_cd_n_s : cd_state;
  assign cts_on_nx = loop_s   ? rts_on :
                     ext_mode ? (rts_on && !ext_cts_n_s) : cts_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_n         <= 1'b1;
      cd_n          <= 1'b1;
      rx_data       <= 1'b1;
      tx_carrier_en <= 1'b0;
    end else begin
      cts_n         <= !cts_on_nx;
      cd_n          <= !cd_on_eff;
      rx_data       <= loop_s ? tx_s : rx_gate(raw_s, cd_on_eff, mute);
      tx_carrier_en <= loop_s ? !car_ctl_n_s : rts_on;
    end
  end

  // Assertions
  assert_cts_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_on) |=> cts_n);

  assert_no_carrier_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_on_eff && !loop_s) |=> rx_data);

  assert_squelch_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && rts_on && !loop_s) |=> rx_data);

  assert_loop_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_s |=> (rx_data == $past(tx_s)));

  assert_carrier_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_s) |=> (tx_carrier_en == $past(rts_on)));

  assert_cd_follows_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_state != $past(cd_state)) |-> ($past(flag_on) == cd_state));
endmodule

// File: tb/fsk_link_sequencer_bench.sv
module fsk_link_sequencer_bench;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rts_n = 1'b1, car_flag_n = 1'b1, rx_raw = 1'b0, tx_data = 1'b1;
  logic sq_off = 1'b0, loop_en = 1'b0, car_ctl_n = 1'b1;
  logic ext_cts_n = 1'b1, ext_cd_n = 1'b1;
  logic [1:0] tsel = 2'b00;
  logic cts_n, cd_n, rx_data, tx_carrier_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fsk_link_sequencer #(.TICK_DIV(DIV)) u_fsk_link_sequencer (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .car_flag_n(car_flag_n),
    .rx_raw(rx_raw), .tx_data(tx_data), .sq_off(sq_off), .loop_en(loop_en),
    .car_ctl_n(car_ctl_n), .ext_cts_n(ext_cts_n), .ext_cd_n(ext_cd_n),
    .tsel(tsel), .cts_n(cts_n), .cd_n(cd_n), .rx_data(rx_data),
    .tx_carrier_en(tx_carrier_en)
  );

  // tsel, clear-to-send ticks, squelch hold ticks
  localparam logic [17:0] VEC [0:2] = '{
    {2'b00, 8'd175, 8'd131},
    {2'b01, 8'd26,  8'd131},
    {2'b10, 8'd61,  8'd35}
  };

  function automatic int lo_cyc(input int n);
    return (n - 1) * DIV;
  endfunction
  function automatic int hi_cyc(input int n);
    return n * DIV + 6;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 cts_n in reset", cts_n, 1'b1);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 cts_n", cts_n, 1'b1);
    chk("R1 cd_n", cd_n, 1'b1);
    chk("R1 rx_data", rx_data, 1'b1);
    chk("R1 tx_carrier_en", tx_carrier_en, 1'b0);
    chk("R6 mark with no carrier", rx_data, 1'b1);

    // R4: carrier-detect on and off windows
    car_flag_n = 1'b0;
    cyc(lo_cyc(9));
    chk("R4 cd still off", cd_n, 1'b1);
    cyc(hi_cyc(9) - lo_cyc(9));
    chk("R4 cd on", cd_n, 1'b0);
    chk("R6 data passes with carrier", rx_data, 1'b0);
    car_flag_n = 1'b1;
    cyc(lo_cyc(4));
    chk("R4 cd still on", cd_n, 1'b0);
    cyc(hi_cyc(4) - lo_cyc(4));
    chk("R4 cd off", cd_n, 1'b1);
    chk("R6 mark after carrier loss", rx_data, 1'b1);

    // R4: glitch restarts the on count
    car_flag_n = 1'b0;
    cyc(5 * DIV);
    car_flag_n = 1'b1;
    cyc(3);
    car_flag_n = 1'b0;
    cyc(lo_cyc(9));
    chk("R4 restart after glitch", cd_n, 1'b1);
    cyc(hi_cyc(9) - lo_cyc(9));
    chk("R4 cd on after restart", cd_n, 1'b0);

    // R2, R3, R5, R10: table of delay sets
    for (int i = 0; i < 3; i++) begin
      tsel = VEC[i][17:16];
      cyc(4);
      rts_n = 1'b0;
      cyc(lo_cyc(int'(VEC[i][15:8])));
      chk("R2 cts still off", cts_n, 1'b1);
      chk("R5 mark during request", rx_data, 1'b1);
      chk("R10 carrier on", tx_carrier_en, 1'b1);
      cyc(hi_cyc(int'(VEC[i][15:8])) - lo_cyc(int'(VEC[i][15:8])));
      chk("R2 cts on", cts_n, 1'b0);
      rts_n = 1'b1;
      cyc(4);
      chk("R3 cts released", cts_n, 1'b1);
      chk("R10 carrier off", tx_carrier_en, 1'b0);
      cyc(lo_cyc(int'(VEC[i][7:0])) - 4);
      chk("R5 hold still mark", rx_data, 1'b1);
      cyc(hi_cyc(int'(VEC[i][7:0])) - lo_cyc(int'(VEC[i][7:0])));
      chk("R5 hold ended", rx_data, 1'b0);
    end

    // R5: a new request during the hold restarts it (tsel 10, 35 ticks)
    rts_n = 1'b0;
    cyc(8);
    rts_n = 1'b1;
    cyc(20 * DIV);
    rts_n = 1'b0;
    cyc(6);
    rts_n = 1'b1;
    cyc(lo_cyc(35));
    chk("R5 hold restarted", rx_data, 1'b1);
    cyc(hi_cyc(35) - lo_cyc(35));
    chk("R5 restarted hold ended", rx_data, 1'b0);

    // R7: squelch disabled
    sq_off = 1'b1;
    cyc(4);
    rts_n = 1'b0;
    cyc(8);
    chk("R7 data during request", rx_data, 1'b0);
    rts_n = 1'b1;
    cyc(8);
    chk("R7 no hold after release", rx_data, 1'b0);
    sq_off = 1'b0;

    // R8: loopback
    loop_en = 1'b1;
    tx_data = 1'b0;
    cyc(5);
    chk("R8 loop data space", rx_data, 1'b0);
    tx_data = 1'b1;
    cyc(4);
    chk("R8 loop data mark", rx_data, 1'b1);
    rts_n = 1'b0;
    cyc(4);
    chk("R8 cts follows rts", cts_n, 1'b0);
    chk("R8 carrier from car_ctl off", tx_carrier_en, 1'b0);
    car_ctl_n = 1'b0;
    cyc(4);
    chk("R8 carrier from car_ctl on", tx_carrier_en, 1'b1);
    rts_n = 1'b1;
    cyc(4);
    chk("R8 cts follows rts off", cts_n, 1'b1);
    car_ctl_n = 1'b1;
    loop_en = 1'b0;
    cyc(hi_cyc(35) + 8);

    // R9: external delay mode
    tsel = 2'b11;
    ext_cd_n = 1'b0;
    rts_n = 1'b0;
    cyc(4);
    chk("R9 cts waits for external", cts_n, 1'b1);
    ext_cts_n = 1'b0;
    cyc(4);
    chk("R9 cts from external", cts_n, 1'b0);
    chk("R9 cd from external", cd_n, 1'b0);
    ext_cts_n = 1'b1;
    cyc(4);
    chk("R9 cts external off", cts_n, 1'b1);
    rts_n = 1'b1;
    cyc(6);
    chk("R9 no internal hold", rx_data, 1'b0);
    ext_cd_n = 1'b1;
    cyc(4);
    chk("R9 cd external off", cd_n, 1'b1);
    chk("R6 mark with external cd off", rx_data, 1'b1);

    finished = 1;
    summary();
    $finish;
  end
endmodule